// File: doc/BRIEF.md
# Sixteen-Pin I/O Bank with Atomic Bit Aliases

This block gives sixteen general-purpose pins a 32-bit memory-mapped register set. Software chooses each pin's direction and output value, reads back the synchronized pin levels, and arms each pin to latch rising, falling or both edges into a status register. Output values, interrupt enables and wake enables can be changed by a full write. They can also be changed through separate set and clear addresses, so that one pin's bit changes without a read-modify-write.

Each pad input is passed through a two-flop synchronizer before edge detection. An edge that matches a pin's trigger mode sets that pin's status bit, and the bit stays set until software writes a one to it. Two level outputs are formed from the status bits: an interrupt request, gated by the interrupt enables, and a wake request, gated by the wake enables.

Top module: `gpio_bank`

## Requirements
- R1: After reset, all pins are inputs (direction register 0xFFFF, `pad_oe` all zero), and the output, interrupt-enable, wake-enable, both edge-control words and status all read 0.
- R2: Offset 0x00 reads the revision, with the major number in bits [7:4] and the minor number in bits [3:0]. Writes to it have no effect.
- R3: Offset 0x30 holds the output values, which drive `pad_out`. Offset 0x34 holds the direction, where a 1 bit makes a pin an input, so `pad_oe` is its bitwise inverse. Offset 0x2C reads the pad levels after two synchronizing flops.
- R4: Writing to a set alias (output 0xF0, interrupt enable 0xDC, wake enable 0xE8) sets every register bit whose data bit is 1 and leaves the other bits unchanged.
- R5: Writing to a clear alias (output 0xB0, interrupt enable 0x9C, wake enable 0xA8) clears every register bit whose data bit is 1 and leaves the other bits unchanged.
- R6: Each pin has a 2-bit trigger field at bit 2*(pin mod 8). Pins 0 to 7 use the word at 0x38 and pins 8 to 15 use the word at 0x3C. The encodings are 00 none, 01 falling, 10 rising and 11 both.
- R7: A synchronized edge that matches a pin's field sets that pin's status bit at 0x18, whatever the enables hold. With field 00, no edge sets the bit.
- R8: Writing to 0x18 clears each status bit whose data bit is 1. Bits written with 0 keep their value.
- R9: When a new edge and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R10: `irq_o` is the OR of status AND interrupt enable. `wake_o` is the OR of status AND wake enable (wake enable at 0x28).
- R11: Offsets outside the map read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one register per cycle |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 16 | Asynchronous pad levels |
| pad_out | output | 16 | Output values to the pads |
| pad_oe | output | 16 | Output enable per pad, high for an output |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Combined wake request |

## Verification
The alias checks assume that a single write never sets and clears the same bit. The bus interface addresses one offset per cycle, and the bench issues one write per cycle, so this always holds. The status checks assume that pad levels change only between clock edges and stay put for at least three cycles. The bench drives each pad on a falling edge and waits four cycles before it samples the result. The sweep walks all sixteen pins through all four trigger modes, with rising and falling edges. A separate, exact-cycle sequence places a clearing write in the same cycle as a detected edge to check R9.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam logic [7:0] OFS_VER      = 8'h00;
    localparam logic [7:0] OFS_STAT     = 8'h18;
    localparam logic [7:0] OFS_IEN      = 8'h1C;
    localparam logic [7:0] OFS_WAKE     = 8'h28;
    localparam logic [7:0] OFS_DIN      = 8'h2C;
    localparam logic [7:0] OFS_DOUT     = 8'h30;
    localparam logic [7:0] OFS_DIR      = 8'h34;
    localparam logic [7:0] OFS_TRIG_LO  = 8'h38;
    localparam logic [7:0] OFS_TRIG_HI  = 8'h3C;
    localparam logic [7:0] OFS_IEN_CLR  = 8'h9C;
    localparam logic [7:0] OFS_WAKE_CLR = 8'hA8;
    localparam logic [7:0] OFS_DOUT_CLR = 8'hB0;
    localparam logic [7:0] OFS_IEN_SET  = 8'hDC;
    localparam logic [7:0] OFS_WAKE_SET = 8'hE8;
    localparam logic [7:0] OFS_DOUT_SET = 8'hF0;

    typedef enum logic [1:0] {
        TRIG_NONE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_BOTH = 2'b11
    } trig_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_VER,
        SEL_STAT,
        SEL_IEN,
        SEL_WAKE,
        SEL_DIN,
        SEL_DOUT,
        SEL_DIR,
        SEL_TRIG_LO,
        SEL_TRIG_HI,
        SEL_IEN_CLR,
        SEL_WAKE_CLR,
        SEL_DOUT_CLR,
        SEL_IEN_SET,
        SEL_WAKE_SET,
        SEL_DOUT_SET
    } regsel_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPINS-1:0]   lvl_i,
    input  logic [2*NPINS-1:0] trig_i,
    output logic [NPINS-1:0]   hit_o
);
    logic [NPINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rise_w;
        logic fall_w;
        logic hit_w;
        assign rise_w = lvl_i[i] & ~prev_q[i];
        assign fall_w = ~lvl_i[i] & prev_q[i];
        always_comb begin
            unique case (trig_e'(trig_i[2*i +: 2]))
                TRIG_NONE: hit_w = 1'b0;
                TRIG_FALL: hit_w = fall_w;
                TRIG_RISE: hit_w = rise_w;
                TRIG_BOTH: hit_w = rise_w | fall_w;
                default:   hit_w = 1'b0;
            endcase
        end
        assign hit_o[i] = hit_w;
    end
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg #(
    parameter int         W   = 16,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_full,
    input  logic [W-1:0] full_d,
    input  logic [W-1:0] set_m,
    input  logic [W-1:0] clr_m,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= RST;
        else if (wr_full) q <= full_d;
        else              q <= (q | set_m) & ~clr_m;
    end

    // R4
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_full && set_m != '0) |=> ((q & $past(set_m)) == $past(set_m)));

    // R5
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_full && clr_m != '0) |=> ((q & $past(clr_m)) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int         NPINS     = 16,
    parameter logic [3:0] REV_MAJOR = 4'd2,
    parameter logic [3:0] REV_MINOR = 4'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq_o,
    output logic              wake_o
);
    localparam int PADW  = 32 - NPINS;
    localparam int TBITS = 2 * NPINS;

    regsel_e          sel;
    logic [NPINS-1:0] wd;
    logic [NPINS-1:0] sync_lvl;
    logic [NPINS-1:0] hit;
    logic [NPINS-1:0] armed;
    logic [NPINS-1:0] stat_q;
    logic [NPINS-1:0] stat_clr;
    logic [NPINS-1:0] dout_q, dir_q, ien_q, wake_q;
    logic [31:0]      trig_q;
    logic             wdata_unused;

    assign wd           = bus_wdata[NPINS-1:0];
    assign wdata_unused = &{1'b0, bus_wdata[31:NPINS]};

    // Address decode
    always_comb begin
        unique case (bus_addr)
            OFS_VER:      sel = SEL_VER;
            OFS_STAT:     sel = SEL_STAT;
            OFS_IEN:      sel = SEL_IEN;
            OFS_WAKE:     sel = SEL_WAKE;
            OFS_DIN:      sel = SEL_DIN;
            OFS_DOUT:     sel = SEL_DOUT;
            OFS_DIR:      sel = SEL_DIR;
            OFS_TRIG_LO:  sel = SEL_TRIG_LO;
            OFS_TRIG_HI:  sel = SEL_TRIG_HI;
            OFS_IEN_CLR:  sel = SEL_IEN_CLR;
            OFS_WAKE_CLR: sel = SEL_WAKE_CLR;
            OFS_DOUT_CLR: sel = SEL_DOUT_CLR;
            OFS_IEN_SET:  sel = SEL_IEN_SET;
            OFS_WAKE_SET: sel = SEL_WAKE_SET;
            OFS_DOUT_SET: sel = SEL_DOUT_SET;
            default:      sel = SEL_NONE;
        endcase
    end

    // Bit-addressable state registers
    gpio_alias_reg #(.W(NPINS), .RST('0)) u_dout (
        .clk(clk), .rst_n(rst_n),
        .wr_full(bus_wr && sel == SEL_DOUT), .full_d(wd),
        .set_m((bus_wr && sel == SEL_DOUT_SET) ? wd : '0),
        .clr_m((bus_wr && sel == SEL_DOUT_CLR) ? wd : '0),
        .q(dout_q));

    gpio_alias_reg #(.W(NPINS), .RST('1)) u_dir (
        .clk(clk), .rst_n(rst_n),
        .wr_full(bus_wr && sel == SEL_DIR), .full_d(wd),
        .set_m('0), .clr_m('0),
        .q(dir_q));

    gpio_alias_reg #(.W(NPINS), .RST('0)) u_ien (
        .clk(clk), .rst_n(rst_n),
        .wr_full(bus_wr && sel == SEL_IEN), .full_d(wd),
        .set_m((bus_wr && sel == SEL_IEN_SET) ? wd : '0),
        .clr_m((bus_wr && sel == SEL_IEN_CLR) ? wd : '0),
        .q(ien_q));

    gpio_alias_reg #(.W(NPINS), .RST('0)) u_wake (
        .clk(clk), .rst_n(rst_n),
        .wr_full(bus_wr && sel == SEL_WAKE), .full_d(wd),
        .set_m((bus_wr && sel == SEL_WAKE_SET) ? wd : '0),
        .clr_m((bus_wr && sel == SEL_WAKE_CLR) ? wd : '0),
        .q(wake_q));

    // Trigger fields: {high word, low word} puts pin i at bits 2i+1:2i
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= '0;
        end else if (bus_wr) begin
            if (sel == SEL_TRIG_LO) trig_q[15:0]  <= bus_wdata[15:0];
            if (sel == SEL_TRIG_HI) trig_q[31:16] <= bus_wdata[15:0];
        end
    end

    // Input path
    gpio_pin_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pad_in), .sync_o(sync_lvl));

    gpio_edge_unit #(.NPINS(NPINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(sync_lvl),
        .trig_i(trig_q[TBITS-1:0]), .hit_o(hit));

    for (genvar i = 0; i < NPINS; i++) begin : g_arm
        assign armed[i] = |trig_q[2*i +: 2];
    end

    // Status: new edge overrides a clear in the same cycle
    assign stat_clr = (bus_wr && sel == SEL_STAT) ? wd : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | hit;
    end

    // Read mux
    always_comb begin
        unique case (sel)
            SEL_VER:     bus_rdata = {24'h0, REV_MAJOR, REV_MINOR};
            SEL_STAT:    bus_rdata = {{PADW{1'b0}}, stat_q};
            SEL_IEN:     bus_rdata = {{PADW{1'b0}}, ien_q};
            SEL_WAKE:    bus_rdata = {{PADW{1'b0}}, wake_q};
            SEL_DIN:     bus_rdata = {{PADW{1'b0}}, sync_lvl};
            SEL_DOUT:    bus_rdata = {{PADW{1'b0}}, dout_q};
            SEL_DIR:     bus_rdata = {{PADW{1'b0}}, dir_q};
            SEL_TRIG_LO: bus_rdata = {16'h0, trig_q[15:0]};
            SEL_TRIG_HI: bus_rdata = {16'h0, trig_q[31:16]};
            default:     bus_rdata = 32'h0;
        endcase
    end

    assign pad_out = dout_q;
    assign pad_oe  = ~dir_q;
    assign irq_o   = |(stat_q & ien_q);
    assign wake_o  = |(stat_q & wake_q);

    // R7
    stat_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~$past(stat_q) & ~$past(armed)) == '0));

    // R8
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_STAT) |=> ((stat_q & $past(wd) & ~$past(hit)) == '0));

    // R10
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ien_q != '0 && stat_q != '0));

    // R10
    wake_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (wake_q != '0 && stat_q != '0));
endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [15:0] pins = 16'h0;
    logic [15:0] pad_out, pad_oe;
    logic        irq_o, wake_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpio_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pins),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_o(irq_o), .wake_o(wake_o));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(8'h34, v); chk("R1 dir", v, 32'hFFFF);
        chk("R1 pad_oe", {16'h0, pad_oe}, 32'h0);
        rd(8'h30, v); chk("R1 dout", v, 32'h0);
        rd(8'h1C, v); chk("R1 ien", v, 32'h0);
        rd(8'h28, v); chk("R1 wake", v, 32'h0);
        rd(8'h38, v); chk("R1 trig lo", v, 32'h0);
        rd(8'h3C, v); chk("R1 trig hi", v, 32'h0);
        rd(8'h18, v); chk("R1 status", v, 32'h0);
        chk("R1 irq/wake", {30'h0, irq_o, wake_o}, 32'h0);

        // R2 revision, write ignored
        rd(8'h00, v); chk("R2 revision", v, 32'h21);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R2 revision after write", v, 32'h21);

        // R3 direction, output, input path
        wr(8'h34, 32'h00FF);
        chk("R3 pad_oe", {16'h0, pad_oe}, 32'hFF00);
        wr(8'h30, 32'h00F0);
        chk("R3 pad_out", {16'h0, pad_out}, 32'h00F0);
        pins = 16'hA5C3;
        settle();
        rd(8'h2C, v); chk("R3 data-in", v, 32'hA5C3);
        pins = 16'h0;
        settle();

        // R4 / R5 aliases
        wr(8'hF0, 32'h0101);
        rd(8'h30, v); chk("R4 dout set", v, 32'h01F1);
        wr(8'hB0, 32'h0030);
        rd(8'h30, v); chk("R5 dout clear", v, 32'h01C1);
        chk("R5 pad_out", {16'h0, pad_out}, 32'h01C1);
        wr(8'hDC, 32'h8001);
        rd(8'h1C, v); chk("R4 ien set", v, 32'h8001);
        wr(8'h9C, 32'h0001);
        rd(8'h1C, v); chk("R5 ien clear", v, 32'h8000);
        wr(8'hE8, 32'h0420);
        rd(8'h28, v); chk("R4 wake set", v, 32'h0420);
        wr(8'hA8, 32'h0400);
        rd(8'h28, v); chk("R5 wake clear", v, 32'h0020);
        wr(8'h1C, 32'h0);
        wr(8'h28, 32'h0);

        // R11 unmapped offsets
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h20, v); chk("R11 unmapped read", v, 32'h0);
        rd(8'h30, v); chk("R11 dout untouched", v, 32'h01C1);
        rd(8'h34, v); chk("R11 dir untouched", v, 32'h00FF);
        rd(8'h1C, v); chk("R11 ien untouched", v, 32'h0);

        // R6 / R7 / R10 sweep: every pin, every trigger mode
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 4; m++) begin
                logic [31:0] cfg;
                logic [31:0] bit_p;
                cfg   = 32'(m) << (2 * p);
                bit_p = 32'h1 << p;
                wr(8'h38, {16'h0, cfg[15:0]});
                wr(8'h3C, {16'h0, cfg[31:16]});
                wr(8'h1C, bit_p);
                wr(8'h18, 32'hFFFF);
                pins[p] = 1'b1;
                settle();
                rd(8'h18, v);
                chk($sformatf("R6 R7 rise pin %0d mode %0d", p, m), v, (m >= 2) ? bit_p : 32'h0);
                chk($sformatf("R10 irq pin %0d mode %0d", p, m), {31'h0, irq_o}, (m >= 2) ? 32'h1 : 32'h0);
                wr(8'h18, 32'hFFFF);
                rd(8'h18, v);
                chk($sformatf("R8 cleared pin %0d", p), v, 32'h0);
                pins[p] = 1'b0;
                settle();
                rd(8'h18, v);
                chk($sformatf("R6 R7 fall pin %0d mode %0d", p, m), v, (m % 2 == 1) ? bit_p : 32'h0);
                wr(8'h18, 32'hFFFF);
            end
        end
        wr(8'h1C, 32'h0);

        // R8 partial clear: pins 3 and 5 rising
        wr(8'h38, 32'h0880);
        wr(8'h3C, 32'h0);
        pins = 16'h0028;
        settle();
        rd(8'h18, v); chk("R7 two pins", v, 32'h0028);
        wr(8'h18, 32'h0008);
        rd(8'h18, v); chk("R8 partial clear", v, 32'h0020);

        // R10 wake and irq gating
        chk("R10 wake off", {31'h0, wake_o}, 32'h0);
        wr(8'hE8, 32'h0020);
        chk("R10 wake on", {31'h0, wake_o}, 32'h1);
        wr(8'hA8, 32'h0020);
        chk("R10 wake removed", {31'h0, wake_o}, 32'h0);
        wr(8'hDC, 32'h0020);
        chk("R10 irq on", {31'h0, irq_o}, 32'h1);
        wr(8'h9C, 32'h0020);
        chk("R10 irq removed", {31'h0, irq_o}, 32'h0);

        // R9 edge and clear in same cycle: pin 3 edge lands with clear of 3 and 5
        pins = 16'h0020;
        settle();
        wr(8'h18, 32'hFFFF);
        wr(8'hDC, 32'h0020);
        pins = 16'h0008;
        settle();
        pins = 16'h0028;
        wr(8'h18, 32'hFFFF);
        pins = 16'h0000;
        settle();
        wr(8'h18, 32'hFFFF);
        wr(8'h38, 32'h0880);
        pins[5] = 1'b1;
        settle();
        rd(8'h18, v); chk("R9 setup pin 5", v, 32'h0020);
        pins[3] = 1'b1;          // on a falling edge
        @(posedge clk);          // first sync flop
        @(negedge clk);
        @(posedge clk);          // second sync flop, edge now detected
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h0028;
        @(posedge clk);          // clear and edge meet here
        @(negedge clk);
        bus_wr = 1'b0;
        rd(8'h18, v); chk("R9 edge beats clear", v, 32'h0008);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule